// File: doc/BRIEF.md
# Write Permission Gate for a Serial Memory with Block Locking

This block sits between the command decoder of a small serial nonvolatile memory and its write engine. For every write request it decides whether the write may go ahead. Array writes are refused inside the address range picked by a two-bit lock selector. Status-register writes are refused while the hardware protect pin is low and the nonvolatile pin-enable bit is set. Neither kind of write is granted unless the write-enable latch is set, and neither is granted while an internal write is running. Reads never pass through this gate. The latch and the nonvolatile bits are stored by the caller, which feeds them in as levels.

A small state machine remembers which kind of write it granted and holds a commit flag for it until the write-in-progress flag falls. Three states are named. `WS_IDLE` is the only state in which a grant can be given. `WS_SR_HOLD` means a status write is being committed. `WS_ARR_HOLD` means an array write is being committed. There are three transitions. *take-status* goes from `WS_IDLE` to `WS_SR_HOLD` on a status grant. *take-array* goes from `WS_IDLE` to `WS_ARR_HOLD` on an array grant. *release* goes from either hold state back to `WS_IDLE` at the first clock edge that sees write-in-progress low after it was high on the edge before.

Because the protect pin is checked only when a grant is given, pulling it low while a status write is in flight does not abort that write. It does block every later status write. Grants are combinational and valid in the same cycle as the request. The commit flags are registered and rise one clock edge after the grant.

Top module: `wprot_gate`

## Requirements
- R1: With lock selector 00, an array write request is granted at every address, including 0x000 and 0x7FF (default 11-bit address).
- R2: With lock selector 01, the top quarter 0x600 to 0x7FF is refused, and 0x5FF and below are granted.
- R3: With lock selector 10, the top half 0x400 to 0x7FF is refused, and 0x3FF and below are granted.
- R4: With lock selector 11, every array address is refused.
- R5: While pin-enable is 1 and the protect pin is 0, every status write request is refused. This frozen mode has no effect on array grants.
- R6: While pin-enable is 0, the protect pin level has no effect and status writes are granted.
- R7: With the write-enable latch at 0, neither grant is ever given.
- R8: While write-in-progress is 1, both grants are 0.
- R9: A status grant raises the status-commit flag at the next clock edge. The flag stays high, whatever the protect pin does, until the edge that sees write-in-progress fall. After that, a status request under frozen mode is refused.
- R10: When status and array requests arrive in the same cycle, only the status request can be granted; the array grant is 0.
- R11: After reset both commit flags are 0 and the gate is idle.
- R12: While either commit flag is high, both grants are 0, even before write-in-progress has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_sel | input | 2 | Block-lock selector: 00 none, 01 top quarter, 10 top half, 11 all |
| wp_en | input | 1 | Nonvolatile pin-enable bit; 1 lets the protect pin freeze the status register |
| wp_n | input | 1 | Hardware protect pin; 0 protects |
| wel | input | 1 | Write-enable latch |
| wip | input | 1 | Internal write in progress |
| addr | input | ADDR_W | Target byte address of an array write |
| sr_req | input | 1 | Status-register write request |
| arr_req | input | 1 | Array write request |
| arr_grant | output | 1 | Array write allowed this cycle |
| sr_grant | output | 1 | Status write allowed this cycle |
| sr_commit | output | 1 | A granted status write is being committed |
| arr_commit | output | 1 | A granted array write is being committed |

## Verification
The bench probes the first and last address on each side of the quarter and half boundaries. A comparator that is off by one, or that decodes the wrong address bit, would refuse 0x5FF or 0x3FF, or grant 0x600 or 0x400. It drops the protect pin in the middle of a committed status write. A gate that reads the pin live would clear the commit flag early, and one that latched protection loosely would go on granting status writes after the write ends. It also drives simultaneous requests and requests made in the window between a grant and the rise of write-in-progress. A gate without priority or without the hold state would grant twice there.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        WS_IDLE     = 2'd0,
        WS_SR_HOLD  = 2'd1,
        WS_ARR_HOLD = 2'd2
    } wstate_t;

    typedef enum logic [1:0] {
        LK_NONE    = 2'b00,
        LK_QUARTER = 2'b01,
        LK_HALF    = 2'b10,
        LK_ALL     = 2'b11
    } lock_t;

endpackage

// File: rtl/wprot_range.sv
module wprot_range
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        lock_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int unsigned SPAN   = 1 << ADDR_W;
    localparam int unsigned HALF_LO = SPAN - (SPAN >> 1);
    localparam int unsigned QUAR_LO = SPAN - (SPAN >> 2);

    logic [ADDR_W:0] addr_x;
    logic            in_half;
    logic            in_quar;

    assign addr_x  = {1'b0, addr};
    assign in_half = (addr_x >= HALF_LO[ADDR_W:0]);
    assign in_quar = (addr_x >= QUAR_LO[ADDR_W:0]);

    always_comb begin
        unique case (lock_t'(lock_sel))
            LK_NONE:    locked = 1'b0;
            LK_QUARTER: locked = in_quar;
            LK_HALF:    locked = in_half;
            LK_ALL:     locked = 1'b1;
            default:    locked = 1'b1;
        endcase
    end

    // quarter range sits inside half range (R2, R3)
    always_comb begin
        assert (!in_quar || in_half) else $error("p_nested_ranges_r2");
    end
endmodule

// File: rtl/wprot_srlock.sv
module wprot_srlock (
    input  logic wp_en,
    input  logic wp_n,
    output logic sr_frozen
);
    // pin has effect only when the enable bit is set (R5, R6)
    assign sr_frozen = wp_en & ~wp_n;
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lock_sel,
    input  logic              wp_en,
    input  logic              wp_n,
    input  logic              wel,
    input  logic              wip,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sr_req,
    input  logic              arr_req,
    output logic              arr_grant,
    output logic              sr_grant,
    output logic              sr_commit,
    output logic              arr_commit
);
    wstate_t state, state_nx;
    logic    wip_q;
    logic    locked;
    logic    sr_frozen;
    logic    idle_ok;
    logic    wip_fell;

    wprot_range #(.ADDR_W(ADDR_W)) u_range (
        .lock_sel (lock_sel),
        .addr     (addr),
        .locked   (locked)
    );

    wprot_srlock u_srlock (
        .wp_en     (wp_en),
        .wp_n      (wp_n),
        .sr_frozen (sr_frozen)
    );

    assign wip_fell = wip_q & ~wip;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_IDLE;
            wip_q <= 1'b0;
        end else begin
            state <= state_nx;
            wip_q <= wip;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE: begin
                if (sr_grant)       state_nx = WS_SR_HOLD;   // take-status
                else if (arr_grant) state_nx = WS_ARR_HOLD;  // take-array
            end
            WS_SR_HOLD:  if (wip_fell) state_nx = WS_IDLE;   // release
            WS_ARR_HOLD: if (wip_fell) state_nx = WS_IDLE;   // release
            default:     state_nx = WS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle_ok    = (state == WS_IDLE) & wel & ~wip;
        sr_grant   = idle_ok & sr_req & ~sr_frozen;
        arr_grant  = idle_ok & arr_req & ~sr_req & ~locked;
        sr_commit  = (state == WS_SR_HOLD);
        arr_commit = (state == WS_ARR_HOLD);
    end

    p_wel_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant || sr_grant) |-> wel);
    p_wip_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !(arr_grant || sr_grant));
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_en && !wp_n) |-> !sr_grant);
    p_full_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_sel == 2'b11) |-> !arr_grant);
    p_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant |=> sr_commit);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_commit && wip) |=> sr_commit);
    p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_grant && sr_grant));
    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_commit || arr_commit) |-> !(arr_grant || sr_grant));
    p_one_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_commit, arr_commit}));
endmodule

// File: tb/wprot_gate_test.sv
module wprot_gate_test;
    localparam int AW = 11;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] lock_sel = '0;
    logic wp_en = 1'b0, wp_n = 1'b1, wel = 1'b0, wip = 1'b0;
    logic [AW-1:0] addr = '0;
    logic sr_req = 1'b0, arr_req = 1'b0;
    logic arr_grant, sr_grant, sr_commit, arr_commit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wprot_gate #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .lock_sel(lock_sel), .wp_en(wp_en),
        .wp_n(wp_n), .wel(wel), .wip(wip), .addr(addr), .sr_req(sr_req),
        .arr_req(arr_req), .arr_grant(arr_grant), .sr_grant(sr_grant),
        .sr_commit(sr_commit), .arr_commit(arr_commit)
    );

    // {lock, wp_en, wp_n, wel, wip, sr_req, arr_req, addr, exp_arr, exp_sr, tag}
    localparam logic [24:0] VEC [NV] = '{
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h7FF,1'b1,1'b0,4'd1},  // R1
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h000,1'b1,1'b0,4'd1},  // R1
        {2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h5FF,1'b1,1'b0,4'd2},  // R2
        {2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h600,1'b0,1'b0,4'd2},  // R2
        {2'd1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h7FF,1'b0,1'b0,4'd2},  // R2
        {2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h3FF,1'b1,1'b0,4'd3},  // R3
        {2'd2,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h400,1'b0,1'b0,4'd3},  // R3
        {2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h000,1'b0,1'b0,4'd4},  // R4
        {2'd3,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,11'h7FF,1'b0,1'b0,4'd4},  // R4
        {2'd0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,11'h000,1'b0,1'b0,4'd5},  // R5
        {2'd0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,11'h000,1'b0,1'b1,4'd5},  // R5
        {2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,11'h000,1'b1,1'b0,4'd5},  // R5
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,11'h000,1'b0,1'b1,4'd6},  // R6
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,11'h000,1'b0,1'b1,4'd6},  // R6
        {2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,11'h123,1'b0,1'b0,4'd7},  // R7
        {2'd0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,11'h000,1'b0,1'b0,4'd7},  // R7
        {2'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,11'h010,1'b0,1'b0,4'd8},  // R8
        {2'd0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,11'h000,1'b0,1'b0,4'd8},  // R8
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,11'h010,1'b0,1'b1,4'd10}, // R10
        {2'd3,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,11'h010,1'b0,1'b0,4'd10}  // R10
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sr_req = 1'b0; arr_req = 1'b0; wip = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #1;
        check("R11 sr_commit in reset", sr_commit, 1'b0);
        check("R11 arr_commit in reset", arr_commit, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R11 sr_commit after reset", sr_commit, 1'b0);
        check("R11 arr_commit after reset", arr_commit, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {lock_sel, wp_en, wp_n, wel, wip, sr_req, arr_req, addr} = VEC[i][24:6];
            #1;
            check($sformatf("R%0d vec%0d arr_grant", VEC[i][3:0], i), arr_grant, VEC[i][5]);
            check($sformatf("R%0d vec%0d sr_grant", VEC[i][3:0], i), sr_grant, VEC[i][4]);
            #1;
            idle_inputs();
        end

        // R9: status write survives a protect-pin drop, later status writes refused
        @(negedge clk);
        lock_sel = 2'd0; wp_en = 1'b1; wp_n = 1'b1; wel = 1'b1; sr_req = 1'b1;
        #1;
        check("R9 status grant", sr_grant, 1'b1);
        @(negedge clk);
        sr_req = 1'b0;
        #1;
        check("R9 commit raised", sr_commit, 1'b1);
        // R12: busy before wip rises
        sr_req = 1'b1; arr_req = 1'b1; wp_n = 1'b1;
        #1;
        check("R12 sr_grant while holding", sr_grant, 1'b0);
        check("R12 arr_grant while holding", arr_grant, 1'b0);
        sr_req = 1'b0; arr_req = 1'b0;
        wip = 1'b1; wp_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            #1;
            check("R9 commit held with pin low", sr_commit, 1'b1);
        end
        wip = 1'b0;
        @(negedge clk);
        #1;
        check("R9 commit released", sr_commit, 1'b0);
        sr_req = 1'b1;
        #1;
        check("R9 later status write refused", sr_grant, 1'b0);
        wp_n = 1'b1;
        #1;
        check("R9 status write after pin high", sr_grant, 1'b1);
        sr_req = 1'b0;

        // R12: array commit path
        @(negedge clk);
        lock_sel = 2'd1; addr = 11'h200; arr_req = 1'b1;
        #1;
        check("R12 array grant", arr_grant, 1'b1);
        @(negedge clk);
        #1;
        check("R12 arr_commit raised", arr_commit, 1'b1);
        check("R12 no second array grant", arr_grant, 1'b0);
        arr_req = 1'b0; wip = 1'b1;
        @(negedge clk);
        wip = 1'b0;
        @(negedge clk);
        #1;
        check("R12 arr_commit released", arr_commit, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule